// File: doc/BRIEF.md
# SPI Master with Self-Managed Chip Select

This block is a single-device SPI master that takes words from an upstream transmit FIFO and hands the words it receives to a downstream receive FIFO. The chip select is never driven by software. It goes active as soon as a word is offered. It stays active while more words follow, so words go out back to back with no gap. It is released only when no word is waiting at the end of a word. A guard interval with chip select high separates transfers.

All sequencing advances only on cycles where the `tick` clock-enable is high, so an external divider sets the serial rate. Each serial bit lasts four ticks: two with SCK at its resting level and two with SCK active. Word length (2 to 32 bits), bit order, clock phase and clock polarity are sampled only while the block is idle. A device-ready input can hold off the start of every word when the phase-one timing is selected.

Top module: `spi_autocs_master`

## Requirements
- R1: Out of reset, `csN` is 1, `mosi` is 0, `rxValid` is 0 and `txReady` is 0. From the first clock after reset, `sck` equals `cfgCpol`.
- R2: The word offered on `txValid`/`txData` is taken (`txReady`=1 for that one tick) when the block is idle, or at the last tick of a word when the receive side is not blocked. `csN` goes low on the tick a word is taken from idle and stays low across words taken at a word end. The empty check and the decision to finish are made on the same tick, so a word present at that tick is always streamed on.
- R3: Between two transfers, `csN` stays high for at least 2 ticks.
- R4: Each bit takes 4 ticks with SCK resting for 2 ticks and active for 2 ticks. With `cfgCpha`=0 the resting pair comes first: `mosi` changes on entry to the resting pair and `miso` is captured on the leading SCK edge.
- R5: With `cfgCpha`=1, chip select is low for 2 resting ticks (front porch) before the first word. The active pair comes first in each bit: `mosi` changes on the leading SCK edge and `miso` is captured on the trailing edge.
- R6: With `cfgCpha`=0, after the last word, SCK rests for 2 ticks with `csN` low (back porch) before `csN` goes high. While `csN` is high the internal SCK is at rest.
- R7: `cfgCpol`=1 only inverts `sck`. The timing is the same for both polarities.
- R8: `cfgWordLen` gives the bits per word as a plain binary count, from 2 to 32. Exactly that many bits are shifted each way per word.
- R9: With `cfgMsbFirst`=1, bit `cfgWordLen`-1 of `txData` goes out first and the first captured bit lands in the MSB of the received word. With 0, bit 0 goes out first and the first captured bit lands in bit 0. `rxData` is right-aligned, and its bits above the word length read 0.
- R10: With `cfgCpha`=1, each word waits after the front porch or word end until `devReady` is 1 on a tick. With `cfgCpha`=0, `devReady` is ignored.
- R11: A finished word is presented on `rxData` with `rxValid`=1 until `rxReady` is seen. If `rxValid` is still pending when the next word finishes, the sequencer stalls in its last tick and overwrites nothing.
- R12: Configuration changes made while a transfer is in progress do not affect that transfer. They take effect once the block is idle again.
- R13: On cycles with `tick`=0, `csN`, `sck` and `mosi` do not change, unless `cfgCpol` changes while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for the serial sequencer |
| cfgWordLen | input | 6 | Bits per word, 2 to 32 |
| cfgMsbFirst | input | 1 | 1: MSB first, 0: LSB first |
| cfgCpha | input | 1 | Clock phase select |
| cfgCpol | input | 1 | SCK resting level |
| txValid | input | 1 | Transmit FIFO has a word |
| txData | input | 32 | Word at the head of the transmit FIFO |
| txReady | output | 1 | Word taken this cycle |
| rxValid | output | 1 | Received word pending |
| rxData | output | 32 | Received word, right-aligned |
| rxReady | input | 1 | Receive FIFO accepts the pending word |
| devReady | input | 1 | Device ready; gates each word when phase is 1 |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |

## Verification
The hardest case to reach is the word-end tick itself. On that tick, the transmit side may be empty or full and the receive side may be blocked or free. These combinations decide whether chip select stays low, a porch starts, or the sequencer freezes. The stimulus loops `mosi` back into `miso`, optionally inverted, so the expected received word follows from the sent word. It holds `rxReady` low across a stream so that a finished word meets a full receive register. It queues words both early and late against the word end. It also changes the configuration in the middle of a transfer and runs with a sparse `tick`, while a behavioural model is compared on every clock.

// File: rtl/spi_autocs_pkg.sv
package spi_autocs_pkg;

  // Per-tick strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // take txData into the transmit shifter
    logic drive;   // put the next bit on mosi
    logic sample;  // capture miso
    logic push;    // present the assembled word to the receive side
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRONT,
    ST_WAITRDY,
    ST_BIT,
    ST_BACK,
    ST_GUARD
  } seqState_t;

endpackage

// File: rtl/spi_autocs_dp.sv
module spi_autocs_dp
  import spi_autocs_pkg::*;
#(
  parameter int MAX_BITS = 32,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  dpStrobe_t           stb,
  input  logic [LEN_W-1:0]    effLen,
  input  logic                effMsb,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                miso,
  input  logic                rxReady,
  output logic                mosi,
  output logic                rxValid,
  output logic [MAX_BITS-1:0] rxData
);

  logic [MAX_BITS-1:0] txShift, rxShift, srcWord, assembled;
  logic [LEN_W-1:0]    shAmt;
  logic                outBit;

  assign shAmt     = LEN_W'(MAX_BITS) - effLen;
  assign srcWord   = stb.load ? (effMsb ? (txData << shAmt) : txData) : txShift;
  assign outBit    = effMsb ? srcWord[MAX_BITS-1] : srcWord[0];
  assign assembled = effMsb ? (rxShift & ({MAX_BITS{1'b1}} >> shAmt))
                            : (rxShift >> shAmt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '0;
      rxShift <= '0;
      mosi    <= 1'b0;
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      if (stb.drive) begin
        mosi    <= outBit;
        txShift <= effMsb ? (srcWord << 1) : (srcWord >> 1);
      end else if (stb.load) begin
        txShift <= srcWord;
      end
      if (stb.sample)
        rxShift <= effMsb ? {rxShift[MAX_BITS-2:0], miso} : {miso, rxShift[MAX_BITS-1:1]};
      if (stb.push) begin
        rxValid <= 1'b1;
        rxData  <= assembled;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  // R11: a pending word is neither dropped nor replaced before it is taken
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  // R13: the data line only moves on enabled cycles
  p_mosi_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mosi));

endmodule

// File: rtl/spi_autocs_ctrl.sv
module spi_autocs_ctrl
  import spi_autocs_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int PORCH_TICKS = 2,
  parameter int GUARD_TICKS = 2,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int CNT_MAX = (PORCH_TICKS > GUARD_TICKS) ? PORCH_TICKS : GUARD_TICKS,
  localparam int CNT_W   = $clog2(CNT_MAX + 1),
  localparam int HI_W    = $clog2(GUARD_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [LEN_W-1:0] cfgWordLen,
  input  logic             cfgMsbFirst,
  input  logic             cfgCpha,
  input  logic             cfgCpol,
  input  logic             txValid,
  input  logic             devReady,
  input  logic             rxValid,
  input  logic             rxReady,
  output logic             txReady,
  output dpStrobe_t        stb,
  output logic [LEN_W-1:0] effLen,
  output logic             effMsb,
  output logic             csN,
  output logic             sck
);

  seqState_t        state, nState;
  logic [1:0]       phase, nPhase;
  logic [LEN_W-1:0] bitsLeft, nBits, heldLen;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             heldMsb, heldCpha, heldCpol, effCpha, effCpol;
  logic             sckInt, lastBit, rxBlocked;
  logic [HI_W-1:0]  csHighTicks;

  // Configuration follows the inputs while idle and is frozen otherwise
  assign effLen  = (state == ST_IDLE) ? cfgWordLen  : heldLen;
  assign effMsb  = (state == ST_IDLE) ? cfgMsbFirst : heldMsb;
  assign effCpha = (state == ST_IDLE) ? cfgCpha     : heldCpha;
  assign effCpol = (state == ST_IDLE) ? cfgCpol     : heldCpol;

  assign lastBit   = (state == ST_BIT) && (phase == 2'd3) && (bitsLeft == '0);
  assign rxBlocked = rxValid && !rxReady;
  assign txReady   = tick && txValid && ((state == ST_IDLE) || (lastBit && !rxBlocked));
  assign sck       = sckInt ^ heldCpol;

  always_comb begin
    nState = state;
    nPhase = phase;
    nBits  = bitsLeft;
    nCnt   = cnt;
    stb    = '0;
    if (tick) begin
      unique case (state)
        ST_IDLE: if (txValid) begin
          stb.load = 1'b1;
          nBits    = effLen - LEN_W'(1);
          nCnt     = '0;
          if (effCpha) nState = ST_FRONT;
          else begin nState = ST_BIT; nPhase = 2'd0; stb.drive = 1'b1; end
        end
        ST_FRONT: begin
          if (cnt == CNT_W'(PORCH_TICKS - 1)) nState = ST_WAITRDY;
          else nCnt = cnt + CNT_W'(1);
        end
        ST_WAITRDY: if (devReady) begin
          nState = ST_BIT; nPhase = 2'd0; stb.drive = 1'b1;
        end
        ST_BIT: begin
          nPhase     = phase + 2'd1;
          stb.sample = (phase == 2'd1);
          if (phase == 2'd3) begin
            if (bitsLeft != '0) begin
              nBits     = bitsLeft - LEN_W'(1);
              stb.drive = 1'b1;
            end else if (rxBlocked) begin
              nPhase = phase;                       // hold in the last tick
            end else begin
              stb.push = 1'b1;
              if (txValid) begin                    // same-tick empty check
                stb.load = 1'b1;
                nBits    = effLen - LEN_W'(1);
                if (effCpha) nState = ST_WAITRDY;
                else stb.drive = 1'b1;
              end else begin
                nCnt   = '0;
                nState = effCpha ? ST_GUARD : ST_BACK;
              end
            end
          end
        end
        ST_BACK: begin
          if (cnt == CNT_W'(PORCH_TICKS - 1)) begin nState = ST_GUARD; nCnt = '0; end
          else nCnt = cnt + CNT_W'(1);
        end
        ST_GUARD: begin
          if (cnt == CNT_W'(GUARD_TICKS - 1)) nState = ST_IDLE;
          else nCnt = cnt + CNT_W'(1);
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitsLeft <= '0;
      cnt      <= '0;
      heldLen  <= LEN_W'(MAX_BITS);
      heldMsb  <= 1'b1;
      heldCpha <= 1'b0;
      heldCpol <= 1'b0;
      csN      <= 1'b1;
      sckInt   <= 1'b0;
    end else begin
      state    <= nState;
      phase    <= nPhase;
      bitsLeft <= nBits;
      cnt      <= nCnt;
      heldLen  <= effLen;
      heldMsb  <= effMsb;
      heldCpha <= effCpha;
      heldCpol <= effCpol;
      csN      <= (nState == ST_IDLE) || (nState == ST_GUARD);
      sckInt   <= (nState == ST_BIT) && (effCpha ? (nPhase < 2'd2) : (nPhase >= 2'd2));
    end
  end

  // Ticks seen with chip select high, saturating at the guard length
  always_ff @(posedge clk) begin
    if (!rst_n) csHighTicks <= HI_W'(GUARD_TICKS);
    else if (!csN) csHighTicks <= '0;
    else if (tick && (csHighTicks < HI_W'(GUARD_TICKS))) csHighTicks <= csHighTicks + HI_W'(1);
  end

  p_cs_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csN) |-> (csHighTicks >= HI_W'(GUARD_TICKS)));

  p_take_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txReady |=> !csN);

  p_sck_rest_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sckInt);

  p_pins_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(csN) && $stable(sckInt)));

endmodule

// File: rtl/spi_autocs_master.sv
module spi_autocs_master
  import spi_autocs_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int PORCH_TICKS = 2,
  parameter int GUARD_TICKS = 2,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [LEN_W-1:0]    cfgWordLen,
  input  logic                cfgMsbFirst,
  input  logic                cfgCpha,
  input  logic                cfgCpol,
  input  logic                txValid,
  input  logic [MAX_BITS-1:0] txData,
  output logic                txReady,
  output logic                rxValid,
  output logic [MAX_BITS-1:0] rxData,
  input  logic                rxReady,
  input  logic                devReady,
  input  logic                miso,
  output logic                sck,
  output logic                csN,
  output logic                mosi
);

  dpStrobe_t        stb;
  logic [LEN_W-1:0] effLen;
  logic             effMsb;

  spi_autocs_ctrl #(
    .MAX_BITS(MAX_BITS), .PORCH_TICKS(PORCH_TICKS), .GUARD_TICKS(GUARD_TICKS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfgWordLen(cfgWordLen), .cfgMsbFirst(cfgMsbFirst), .cfgCpha(cfgCpha), .cfgCpol(cfgCpol),
    .txValid(txValid), .devReady(devReady), .rxValid(rxValid), .rxReady(rxReady),
    .txReady(txReady), .stb(stb), .effLen(effLen), .effMsb(effMsb),
    .csN(csN), .sck(sck)
  );

  spi_autocs_dp #(.MAX_BITS(MAX_BITS)) dp_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stb(stb),
    .effLen(effLen), .effMsb(effMsb), .txData(txData), .miso(miso),
    .rxReady(rxReady), .mosi(mosi), .rxValid(rxValid), .rxData(rxData)
  );

endmodule

// File: tb/spi_autocs_master_tb_top.sv
module spi_autocs_master_tb_top;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        tick = 1'b0, txValid = 1'b0, devReady = 1'b0, rxReady = 1'b1;
  logic        cfgMsbFirst = 1'b1, cfgCpha = 1'b0, cfgCpol = 1'b0;
  logic [5:0]  cfgWordLen = 6'd8;
  logic [31:0] txData = '0;
  logic        txReady, rxValid, sck, csN, mosi, miso;
  logic [31:0] rxData;
  bit          flip = 1'b0;
  assign miso = mosi ^ flip;

  spi_autocs_master dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfgWordLen(cfgWordLen),
    .cfgMsbFirst(cfgMsbFirst), .cfgCpha(cfgCpha), .cfgCpol(cfgCpol),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady), .devReady(devReady),
    .miso(miso), .sck(sck), .csN(csN), .mosi(mosi)
  );

  int checks = 0, errors = 0, cyc = 0, tickDiv = 1, rxGot = 0, hiTicks = 99;
  logic [31:0] txQ[$];
  string tagCs = "R2", tagSck = "R4", tagMosi = "R9", tagRx = "R9";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Behavioural reference: 0 idle,1 front,2 wait ready,3 bit,4 back,5 guard
  int          mSt = 0, mCnt = 0, mPh = 0, mBits = 0, mK = 0, mLen = 32;
  bit          mMsb = 1, mCpha = 0, mCpol = 0;
  logic [31:0] mWord = '0, eRxD = '0;
  bit          eCs = 1, eSckI = 0, eMosi = 0, eRxV = 0;

  function automatic logic [31:0] lenMask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic loadWord();
    mWord = txQ.pop_front();
    mBits = mLen - 1;
    mK    = 0;
  endtask

  task automatic driveBit();
    int idx = mMsb ? (mLen - 1 - mK) : mK;
    eMosi = mWord[idx];
  endtask

  task automatic startBit();
    mSt = 3; mPh = 0; driveBit();
  endtask

  always @(posedge clk) begin : refModel
    bit blocked, pop, lastB;
    if (!rst_n) begin
      mSt = 0; mCnt = 0; mPh = 0; mBits = 0; mK = 0;
      mLen = 32; mMsb = 1; mCpha = 0; mCpol = 0;
      eCs = 1; eSckI = 0; eMosi = 0; eRxV = 0; eRxD = '0;
    end else begin
      if (mSt == 0) begin
        mLen = int'(cfgWordLen); mMsb = cfgMsbFirst; mCpha = cfgCpha; mCpol = cfgCpol;
      end
      blocked = eRxV && !rxReady;
      lastB   = (mSt == 3) && (mPh == 3) && (mBits == 0);
      pop     = tick && txValid && ((mSt == 0) || (lastB && !blocked));
      chk(txReady === pop, "R2", "txReady", txReady, pop);
      if (eRxV && rxReady) begin
        chk(rxData === eRxD, tagRx, "rxData", rxData, eRxD);
        rxGot++;
        eRxV = 0;
      end
      if (csN && tick) hiTicks++;
      if (tick) begin
        case (mSt)
          0: if (txValid) begin
               loadWord();
               if (mCpha) begin mSt = 1; mCnt = 0; end else startBit();
             end
          1: if (mCnt == 1) mSt = 2; else mCnt++;
          2: if (devReady) startBit();
          3: if (mPh < 3) mPh++;
             else if (mBits > 0) begin mBits--; mK++; mPh = 0; driveBit(); end
             else if (!blocked) begin
               eRxV = 1;
               eRxD = (mWord ^ (flip ? 32'hFFFF_FFFF : 32'h0)) & lenMask(mLen);
               if (txValid) begin
                 loadWord();
                 if (mCpha) mSt = 2; else startBit();
               end else begin
                 mSt = mCpha ? 5 : 4; mCnt = 0;
               end
             end
          4: if (mCnt == 1) begin mSt = 5; mCnt = 0; end else mCnt++;
          5: if (mCnt == 1) mSt = 0; else mCnt++;
          default: mSt = 0;
        endcase
      end
      eCs   = (mSt == 0) || (mSt == 5);
      eSckI = (mSt == 3) && (mCpha ? (mPh < 2) : (mPh >= 2));
    end
  end

  // Compare registered outputs away from the edge, then drive the FIFO side
  bit prevCs = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(csN === eCs, tagCs, "csN", csN, eCs);
      chk(sck === (eSckI ^ mCpol), tagSck, "sck", sck, eSckI ^ mCpol);
      chk(mosi === eMosi, tagMosi, "mosi", mosi, eMosi);
      chk(rxValid === eRxV, "R11", "rxValid", rxValid, eRxV);
      if (prevCs && !csN) chk(hiTicks >= 2, "R3", "csN high ticks", hiTicks, 2);
      if (!csN) hiTicks = 0;
      prevCs = csN;
    end
    cyc++;
    tick    = ((cyc % tickDiv) == 0);
    txValid = (txQ.size() > 0);
    txData  = txValid ? txQ[0] : 32'h0;
  end

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    finishRun();
  end

  task automatic setCfg(int len, bit msb, bit cpha, bit cpol, bit inv);
    cfgWordLen = 6'(len); cfgMsbFirst = msb; cfgCpha = cpha; cfgCpol = cpol; flip = inv;
  endtask

  task automatic queueWords(int n, logic [31:0] seed);
    for (int i = 0; i < n; i++) txQ.push_back(seed * (i + 3) ^ 32'h5A3C_96E1 ^ (seed >> i));
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(txQ.size() == 0 && mSt == 0 && !rxValid && csN));
    repeat (6) @(negedge clk);
  endtask

  task automatic expectWords(int n, string tag);
    chk(rxGot == n, tag, "words received", rxGot, n);
    rxGot = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(csN === 1'b1, "R1", "csN after reset", csN, 1);
    chk(sck === cfgCpol, "R1", "sck after reset", sck, cfgCpol);
    chk(mosi === 1'b0, "R1", "mosi after reset", mosi, 0);
    chk(rxValid === 1'b0, "R1", "rxValid after reset", rxValid, 0);
    chk(txReady === 1'b0, "R1", "txReady after reset", txReady, 0);

    // Phase 0, MSB first, 8 bits, back-to-back stream; devReady low is ignored (R10)
    tagCs = "R2 R6 R10"; tagSck = "R4"; tagMosi = "R4 R9"; tagRx = "R8 R9";
    setCfg(8, 1, 0, 0, 0); devReady = 1'b0; tickDiv = 1;
    queueWords(3, 32'h1357_9BDF);
    waitIdle();
    expectWords(3, "R8 R10");

    // Separate transfers: a second word queued after the first has finished
    queueWords(1, 32'h0F0F_1234);
    waitIdle();
    queueWords(1, 32'h7777_8888);
    waitIdle();
    expectWords(2, "R3");

    // Phase 0, LSB first, 32 bits, inverted SCK, sparse tick, receive side held off
    tagCs = "R2 R6 R11"; tagSck = "R4 R7 R13"; tagMosi = "R9 R13"; tagRx = "R9 R11";
    setCfg(32, 0, 0, 1, 1); tickDiv = 3; rxReady = 1'b0;
    queueWords(3, 32'hCAFE_0451);
    repeat (1000) @(negedge clk);
    chk(rxValid === 1'b1, "R11", "rxValid while held", rxValid, 1);
    chk(csN === 1'b0, "R11", "csN during stall", csN, 0);
    rxReady = 1'b1;
    waitIdle();
    expectWords(3, "R8 R11");

    // Phase 1, MSB first, 2-bit words, gated by devReady
    tagCs = "R2 R5 R10"; tagSck = "R5 R10"; tagMosi = "R5 R9"; tagRx = "R5 R8";
    setCfg(2, 1, 1, 0, 0); tickDiv = 1; devReady = 1'b0;
    queueWords(2, 32'h0000_0006);
    repeat (40) @(negedge clk);
    chk(csN === 1'b0, "R10", "csN while not ready", csN, 0);
    chk(sck === 1'b0, "R10", "sck rests while not ready", sck, 0);
    chk(rxGot == 0 && !rxValid, "R10", "no word while not ready", rxGot, 0);
    devReady = 1'b1;
    repeat (20) @(negedge clk);
    devReady = 1'b0;
    repeat (30) @(negedge clk);
    devReady = 1'b1;
    waitIdle();
    expectWords(2, "R8 R10");

    // Phase 1, LSB first, 13 bits, inverted SCK, divided tick
    tagCs = "R2 R5"; tagSck = "R5 R7"; tagMosi = "R5 R9"; tagRx = "R8 R9";
    setCfg(13, 0, 1, 1, 1); tickDiv = 2;
    queueWords(3, 32'hBEEF_0102);
    waitIdle();
    expectWords(3, "R8 R9");

    // Configuration changed mid-transfer must not alter the running stream
    tagCs = "R12"; tagSck = "R12"; tagMosi = "R12"; tagRx = "R12";
    setCfg(8, 1, 0, 0, 0); tickDiv = 1;
    queueWords(2, 32'h2468_ACE0);
    repeat (12) @(negedge clk);
    cfgWordLen = 6'd5; cfgMsbFirst = 1'b0; cfgCpha = 1'b1; cfgCpol = 1'b1;
    waitIdle();
    expectWords(2, "R12");
    chk(sck === 1'b1, "R12 R7", "new polarity once idle", sck, 1);

    finishRun();
  end

endmodule